// File: doc/BRIEF.md
# Sequential Booth Signed Multiplier

This block multiplies two signed two's-complement words of `WIDTH` bits over several clock cycles and returns a `2*WIDTH`-bit signed product. It examines the multiplier one bit per cycle, together with a reference bit that holds the bit examined in the cycle before. Depending on that pair, it adds the multiplicand into the upper half of a double-width accumulator, subtracts it from that half, or leaves the half alone. It then shifts the whole accumulator right arithmetically by one place.

A caller drives both operands and pulses `start` while the block is idle. `busy` stays high for exactly `WIDTH` cycles. In the cycle after the last step, `done` pulses for one cycle and the product is valid. The product stays on `product` until the next accepted start. A start that arrives while the block is working has no effect.

Top module: `booth_seq_mult`

## Requirements
- R1: After reset, `busy` is 0, `done` is 0 and `product` is 0.
- R2: A `start` seen at a rising edge while `busy` is 0 captures both operands, clears both accumulator halves, and sets `busy` at that edge.
- R3: When a start is accepted, the reference bit below the multiplier LSB is set to 0.
- R4: A (current bit, reference bit) pair of 00 or 11 leaves the upper half unchanged before the shift.
- R5: A pair of 01 adds the multiplicand into the upper half before the shift.
- R6: A pair of 10 subtracts the multiplicand from the upper half before the shift.
- R7: Each step shifts the upper and lower halves right arithmetically as one word, and the lower half's LSB is discarded.
- R8: Each step rotates the multiplier copy right by one, and the bit that leaves its LSB becomes the new reference bit.
- R9: Exactly `WIDTH` steps follow an accepted start. `done` rises at the `WIDTH`-th rising edge after the start edge, and `product` then equals the signed product of the operands.
- R10: The add and subtract are computed with `WIDTH+1` sign-extended bits, so the most negative value times itself yields the correct positive product.
- R11: `done` is high for one cycle only, and `busy` is 0 whenever `done` is 1.
- R12: A `start` while `busy` is 1 is ignored: the operands, the step count and the final result are unaffected.
- R13: `product` holds its value from `done` until the next accepted start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Request to begin a multiply; accepted only while idle |
| mcand | input | WIDTH | Signed multiplicand, sampled at an accepted start |
| mplier | input | WIDTH | Signed multiplier, sampled at an accepted start |
| busy | output | 1 | High while steps are in progress |
| done | output | 1 | One-cycle pulse when the product is ready |
| product | output | 2*WIDTH | Signed product, valid from `done` until the next start |

## Verification
The bench builds the block with `WIDTH` set to 6, which makes a full sweep of all 4096 signed operand pairs cheap. That sweep covers every bit pattern the recoder can see, including long runs of ones, isolated ones, zero, minus one, and both operands at the most negative value. Each vector also checks the exact cycle of `done`, that `done` lasts one cycle, and that the product is held afterwards. Separate runs inject a start partway through a multiply.

// File: rtl/booth_pkg.sv
// Package: shared types for the sequential Booth multiplier.
// Assumes: nothing beyond the standard language.
package booth_pkg;

    // Action taken on the upper accumulator half in one step.
    typedef enum logic [1:0] {
        OP_HOLD = 2'd0,
        OP_ADD  = 2'd1,
        OP_SUB  = 2'd2
    } booth_op_e;

    // Maps (current multiplier bit, reference bit) to a step action.
    function automatic booth_op_e booth_decode(input logic cur, input logic prev);
        case ({cur, prev})
            2'b01:   booth_decode = OP_ADD;
            2'b10:   booth_decode = OP_SUB;
            default: booth_decode = OP_HOLD;
        endcase
    endfunction

endpackage

// File: rtl/booth_seq_ctrl.sv
// Module: booth_seq_ctrl
// Sequences one multiply: accepts start only while idle, then issues
// exactly WIDTH step strobes and pulses done for one cycle afterwards.
// Assumes: WIDTH >= 2; synchronous active-low reset.
module booth_seq_ctrl #(
    parameter int WIDTH = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    output logic load,
    output logic step,
    output logic busy,
    output logic done
);
    localparam int CNT_W = $clog2(WIDTH + 1);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(WIDTH - 1);

    logic             busy_q;
    logic             done_q;
    logic [CNT_W-1:0] cnt_q;
    logic             last_step;

    // Decode strobes for the datapath from the current state.
    always_comb begin
        load      = start && !busy_q;
        step      = busy_q;
        last_step = busy_q && (cnt_q == LAST);
    end

    // Busy flag, step counter and done pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy_q <= 1'b0;
            done_q <= 1'b0;
            cnt_q  <= '0;
        end else begin
            done_q <= last_step;
            if (load) begin
                busy_q <= 1'b1;
                cnt_q  <= '0;
            end else if (last_step) begin
                busy_q <= 1'b0;
                cnt_q  <= '0;
            end else if (busy_q) begin
                cnt_q  <= cnt_q + 1'b1;
            end
        end
    end

    assign busy = busy_q;
    assign done = done_q;

    // R11: done lasts exactly one cycle.
    p_done_pulse_r11: assert property (@(posedge clk) disable iff (!rst_n)
        done_q |=> !done_q);
    // R11: the block is idle whenever done is high.
    p_done_idle_r11: assert property (@(posedge clk) disable iff (!rst_n)
        done_q |-> !busy_q);
    // R2: an accepted start makes the block busy at the first step.
    p_start_busy_r2: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> (busy_q && cnt_q == '0));
    // R12: a start while busy does not restart the count.
    p_ignore_start_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_q && !last_step) |=> (busy_q && cnt_q == $past(cnt_q) + 1'b1));
    // R9: done is only reached through the last step.
    p_done_after_step_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(done_q) |-> $past(busy_q));

endmodule

// File: rtl/booth_step_dp.sv
// Module: booth_step_dp
// Holds the multiplicand, the two accumulator halves, the rotating
// multiplier copy and its reference bit; performs one Booth step per strobe.
// Assumes: load and step are never high together (guaranteed by control).
module booth_step_dp
    import booth_pkg::*;
#(
    parameter int WIDTH = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               load,
    input  logic               step,
    input  logic [WIDTH-1:0]   mcand,
    input  logic [WIDTH-1:0]   mplier,
    output logic [2*WIDTH-1:0] product
);
    localparam int EXT_W = WIDTH + 1;

    logic [WIDTH-1:0] mc_q;
    logic [WIDTH-1:0] hi_q;
    logic [WIDTH-1:0] lo_q;
    logic [WIDTH-1:0] mq_q;
    logic             ref_q;

    booth_op_e        op;
    logic [EXT_W-1:0] hi_ext;
    logic [EXT_W-1:0] mc_ext;
    logic [EXT_W-1:0] sum;

    // Sign-extended add, subtract or hold on the upper half.
    always_comb begin
        op     = booth_decode(mq_q[0], ref_q);
        hi_ext = {hi_q[WIDTH-1], hi_q};
        mc_ext = {mc_q[WIDTH-1], mc_q};
        case (op)
            OP_ADD:  sum = hi_ext + mc_ext;
            OP_SUB:  sum = hi_ext - mc_ext;
            default: sum = hi_ext;
        endcase
    end

    // Operand capture on load; combined shift and rotation on each step.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mc_q  <= '0;
            hi_q  <= '0;
            lo_q  <= '0;
            mq_q  <= '0;
            ref_q <= 1'b0;
        end else if (load) begin
            mc_q  <= mcand;
            hi_q  <= '0;
            lo_q  <= '0;
            mq_q  <= mplier;
            ref_q <= 1'b0;
        end else if (step) begin
            hi_q  <= sum[EXT_W-1:1];
            lo_q  <= {sum[0], lo_q[WIDTH-1:1]};
            mq_q  <= {mq_q[0], mq_q[WIDTH-1:1]};
            ref_q <= mq_q[0];
        end
    end

    assign product = {hi_q, lo_q};

    // R3: the reference bit starts cleared.
    p_ref_clear_r3: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> (ref_q == 1'b0));
    // R2: both accumulator halves start at zero.
    p_acc_clear_r2: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> (hi_q == '0 && lo_q == '0));
    // R8: the dropped multiplier LSB becomes the reference bit.
    p_ref_follow_r8: assert property (@(posedge clk) disable iff (!rst_n)
        step |=> (ref_q == $past(mq_q[0])));
    // R4: a hold step only shifts the upper half.
    p_hold_shift_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (step && op == OP_HOLD) |=>
            (hi_q == {$past(hi_q[WIDTH-1]), $past(hi_q[WIDTH-1:1])}));
    // R7: the lower half takes in one bit from above and drops its LSB.
    p_lo_shift_r7: assert property (@(posedge clk) disable iff (!rst_n)
        step |=> (lo_q[WIDTH-2:0] == $past(lo_q[WIDTH-1:1])));
    // R12: the multiplicand is not disturbed while stepping.
    p_mcand_held_r12: assert property (@(posedge clk) disable iff (!rst_n)
        step |=> $stable(mc_q));
    // R13: with no load and no step the product is held.
    p_product_hold_r13: assert property (@(posedge clk) disable iff (!rst_n)
        (!load && !step) |=> $stable(product));

endmodule

// File: rtl/booth_seq_mult.sv
// Module: booth_seq_mult (top)
// Sequential radix-2 Booth signed multiplier: WIDTH steps per product.
// Assumes: operands are stable only at the accepted start edge.
module booth_seq_mult #(
    parameter int WIDTH = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               start,
    input  logic [WIDTH-1:0]   mcand,
    input  logic [WIDTH-1:0]   mplier,
    output logic               busy,
    output logic               done,
    output logic [2*WIDTH-1:0] product
);
    logic load;
    logic step;

    // Control: start acceptance, step count, done pulse.
    booth_seq_ctrl #(.WIDTH(WIDTH)) u_ctrl (
        .clk   (clk),
        .rst_n (rst_n),
        .start (start),
        .load  (load),
        .step  (step),
        .busy  (busy),
        .done  (done)
    );

    // Datapath: accumulator, multiplier rotation, add/subtract.
    booth_step_dp #(.WIDTH(WIDTH)) u_dp (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (load),
        .step    (step),
        .mcand   (mcand),
        .mplier  (mplier),
        .product (product)
    );

    // R11: done and busy are never high together at the ports.
    p_port_excl_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !(done && busy));

endmodule

// File: tb/booth_seq_mult_tb.sv
module booth_seq_mult_tb;
    localparam int TW = 6;
    localparam int LO = -(1 << (TW - 1));
    localparam int HI = (1 << (TW - 1)) - 1;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            start = 1'b0;
    logic [TW-1:0]   mcand = '0;
    logic [TW-1:0]   mplier = '0;
    logic            busy;
    logic            done;
    logic [2*TW-1:0] product;

    int  n_checks = 0;
    int  n_fail = 0;
    bit  finished = 1'b0;

    always #4 clk = ~clk;  // 125 MHz

    booth_seq_mult #(.WIDTH(TW)) u_dut (
        .clk     (clk),
        .rst_n   (rst_n),
        .start   (start),
        .mcand   (mcand),
        .mplier  (mplier),
        .busy    (busy),
        .done    (done),
        .product (product)
    );

    task automatic check(input bit ok, input string req, input string what,
                         input longint act, input longint exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    // Runs one multiply; inject>0 pulses a second start at that step.
    task automatic run(input int a, input int b, input int inject, input string req);
        int e;
        logic [2*TW-1:0] ev;
        bit ok;
        e  = a * b;
        ev = e[2*TW-1:0];
        @(negedge clk);
        mcand  = a[TW-1:0];
        mplier = b[TW-1:0];
        start  = 1'b1;
        @(negedge clk);
        start  = 1'b0;
        ok = busy && !done;
        for (int k = 1; k < TW; k++) begin
            if (k == inject) begin
                mcand  = 3;
                mplier = 3;
                start  = 1'b1;
            end
            @(negedge clk);
            start = 1'b0;
            ok = ok && busy && !done;
        end
        @(negedge clk);
        ok = ok && done && !busy && (product == ev);
        check(ok, req, "done timing / product", longint'($signed(product)), longint'(e));
        @(negedge clk);
        check(!done && product == ev, req, "one-cycle done, held product",
              longint'($signed(product)), longint'(e));
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset state
        check(busy == 0 && done == 0 && product == '0, "R1", "reset state",
              longint'(product), 0);
        rst_n = 1'b1;
        // R10: most negative times most negative, and with +max
        run(LO, LO, 0, "R10");
        run(LO, HI, 0, "R10");
        // R12: start while busy ignored, at early and late steps
        run(5, -7, 2, "R12");
        run(-13, 11, TW - 1, "R12");
        // R13: product held over idle cycles
        repeat (5) @(negedge clk);
        check(product == 12'(-143), "R13", "held across idle",
              longint'($signed(product)), -143);
        // R3 R4 R5 R6 R7 R8 R9 R11: exhaustive sweep of all operand pairs
        for (int a = LO; a <= HI; a++)
            for (int b = LO; b <= HI; b++)
                run(a, b, 0, "R2_R3_R4_R5_R6_R7_R8_R9_R11");
        finished = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
            $finish;
        end
    end
endmodule